// File: doc/BRIEF.md
# Word-Level Synchronous Serial Audio Port

This block is the word-level core of a synchronous serial audio port for 24-bit signal-processor samples. It does not drive serial pins. Instead, an external shifter signals a transmit or receive word event. On a transmit event the block delivers the transmit word, trimmed to the configured length. On a receive event it takes a parallel word from the line side and stores it, left-justified. Software configures the block and moves data through a small synchronous register bus. The bus has one-cycle read and write strobes and a combinational read-data path.

Two configuration registers hold the settings. One holds the word-length code and a frame-rate divider field. The other holds the enables, the interrupt enables, the network/normal mode bit, the bit-order bit, the sync bit and the clock-direction bit. Each direction waits for a frame sync after it is enabled. Frame syncs can come from the line side. They can also come from a general-purpose port handshake, which the block uses to open a receive frame, to arm or disarm transmit, and to emit frame-sync pulses of its own. The asynchronous reset is released through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `ssi_word_port`

## Requirements
- R1: On a transmit event, `tx_data` becomes the top L bits of the transmit word, right-aligned with zeros above them. L is 8, 12, 16 or 24 for word-length codes 0, 1, 2 and 3.
- R2: On a receive event that is accepted, the RX word becomes the low L bits of `rx_in`, placed in the top L bits, with zeros below.
- R3: When the bit-order bit (control B bit 5) is 1, the L-bit field is bit-reversed before it is placed, in both directions.
- R4: A transmit event drives `tx_data` to 0 if transmit enable (control B bit 0) is clear or a transmit frame wait is pending. Every transmit event sets the transmit-empty flag (status bit 0).
- R5: A receive event loads RX with 0 if receive enable (control B bit 1) is clear or a receive frame wait is pending. Every receive event sets the receive-full flag (status bit 1).
- R6: Writing an enable bit from 0 to 1 sets that direction's frame wait. A line frame-sync strobe with value 1 clears the wait only in network mode (control B bit 4 = 1). In normal mode the strobe leaves the wait pending.
- R7: On a line frame-sync strobe, the matching frame flag (status bit 2 for transmit, bit 3 for receive) takes the strobe value in network mode and becomes 1 in normal mode.
- R8: A write to the TX word (address 3) or any write to status (address 2) clears transmit-empty. A read of RX (address 4) clears receive-full. A transmit or receive event in the same cycle wins over the clear.
- R9: `tx_irq` or `rx_irq` pulses for one cycle after an event that passed data, if the matching interrupt enable (control B bit 2 or bit 3) is set.
- R10: After reset, status reads 1 (transmit-empty only), both control registers read 0, `tx_data` is 0 and both frame waits are pending.
- R11: `frame_div` equals control A bits 6:2 plus one.
- R12: A port handshake strobe works as follows. Direction and value bit 0 both set clears the receive wait and pulses `hs_rx_sync`. With direction bit 1 set and value bit 1 set, the strobe clears the transmit wait and arms transmit. With direction bit 1 set and value bit 1 clear, it disarms transmit and pulses `hs_tx_sync_stb` with value 0. A TX write while armed pulses `hs_tx_sync_stb` with value 1.
- R13: The register map is: address 0 is control A (word length in bits 1:0), address 1 is control B (8 bits, clock direction in bit 7, sync in bit 6), address 2 is status, address 3 is the TX word and address 4 is the RX word. Reads return the stored fields zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data, combinational from the address |
| tx_evt | input | 1 | Transmit word event |
| tx_data | output | 24 | Word delivered to the line side |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_evt | input | 1 | Receive word event |
| rx_in | input | 24 | Word from the line side, right-aligned |
| rx_irq | output | 1 | Receive interrupt pulse |
| fs_tx_stb | input | 1 | Transmit frame-sync strobe |
| fs_tx_val | input | 1 | Transmit frame-sync value |
| fs_rx_stb | input | 1 | Receive frame-sync strobe |
| fs_rx_val | input | 1 | Receive frame-sync value |
| pc_stb | input | 1 | Port handshake strobe |
| pc_dir | input | 2 | Port handshake direction bits (bit 0 receive, bit 1 transmit) |
| pc_val | input | 2 | Port handshake value bits |
| hs_rx_sync | output | 1 | Receive frame-sync pulse created by the handshake |
| hs_tx_sync_stb | output | 1 | Transmit frame-sync pulse created by the handshake |
| hs_tx_sync_val | output | 1 | Value carried by that pulse |
| frame_div | output | 6 | Frame-rate divider |

## Verification
The assertions assume that every strobe input (events, frame syncs, handshake and bus strobes) is a level sampled on the rising edge. They also assume that a strobe is not held across edges unless repeated action is intended. The bench drives every input on the falling edge and holds each strobe for exactly one cycle, so every event is counted once. Reads and writes never overlap in the same cycle, except in the single directed case that checks event-over-clear priority.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

  localparam int WORD_W  = 24;
  localparam int ADDR_W  = 3;
  localparam int DIV_W   = 5;
  localparam int CA_W    = 2 + DIV_W;

  localparam logic [ADDR_W-1:0] ADR_CTLA = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CTLB = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_TXW  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_RXW  = 3'd4;

  // control B, bit 0 at the bottom of the struct
  typedef struct packed {
    logic sckd;
    logic sync;
    logic shfd;
    logic net;
    logic rie;
    logic tie;
    logic re;
    logic te;
  } ctlb_t;

  typedef struct packed {
    logic rfs;
    logic tfs;
    logic rdf;
    logic tde;
  } stat_t;

endpackage

// File: rtl/ssi_word_shaper.sv
module ssi_word_shaper
  import ssi_pkg::*;
#(
  parameter int DATA_W  = WORD_W,
  parameter bit TO_LINE = 1'b1
) (
  input  logic [1:0]        wl_code,
  input  logic              reverse,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int NLEN = 4;

  logic [DATA_W-1:0] cand [NLEN];

  for (genvar k = 0; k < NLEN; k++) begin : g_len
    localparam int LEN = (k == 0) ? DATA_W / 3 :
                         (k == 1) ? DATA_W / 2 :
                         (k == 2) ? (2 * DATA_W) / 3 : DATA_W;
    logic [LEN-1:0]    field;
    logic [LEN-1:0]    flipped;
    logic [LEN-1:0]    chosen;
    logic [DATA_W-1:0] placed;

    if (TO_LINE) begin : g_tx
      assign field = din[DATA_W-1 -: LEN];
    end else begin : g_rx
      assign field = din[LEN-1:0];
    end

    always_comb begin
      for (int i = 0; i < LEN; i++) begin
        flipped[i] = field[LEN-1-i];
      end
    end

    assign chosen = reverse ? flipped : field;

    if (TO_LINE) begin : g_tx_place
      always_comb begin
        placed = '0;
        placed[LEN-1:0] = chosen;
      end
    end else begin : g_rx_place
      always_comb begin
        placed = '0;
        placed[DATA_W-1 -: LEN] = chosen;
      end
    end

    assign cand[k] = placed;
  end

  assign dout = cand[wl_code];

endmodule

// File: rtl/ssi_ctl_regs.sv
module ssi_ctl_regs
  import ssi_pkg::*;
#(
  parameter int DW_DIV = DIV_W,
  localparam int CAW   = 2 + DW_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic [CAW-1:0]    ca_wdata,
  input  ctlb_t             cb_wdata,
  input  logic              tx_wr,
  input  logic              fs_tx_stb,
  input  logic              fs_tx_val,
  input  logic              fs_rx_stb,
  input  logic              fs_rx_val,
  input  logic              pc_stb,
  input  logic [1:0]        pc_dir,
  input  logic [1:0]        pc_val,
  output logic [1:0]        wl_code,
  output logic [DW_DIV-1:0] div_field,
  output ctlb_t             ctlb,
  output logic              wait_tx,
  output logic              wait_rx,
  output logic              hs_rx_sync,
  output logic              hs_tx_sync_stb,
  output logic              hs_tx_sync_val
);

  logic [1:0]        wl_q, wl_d;
  logic [DW_DIV-1:0] div_q, div_d;
  ctlb_t             cb_q, cb_d;
  logic              wtx_q, wtx_d, wrx_q, wrx_d;
  logic              play_q, play_d;
  logic              hrx_q, hrx_d;
  logic              htx_stb_q, htx_stb_d, htx_val_q, htx_val_d;

  always_comb begin
    wl_d  = wl_q;
    div_d = div_q;
    cb_d  = cb_q;
    if (wr_a) {div_d, wl_d} = ca_wdata;
    if (wr_b) cb_d = cb_wdata;

    wtx_d = wtx_q;
    if (fs_tx_stb && fs_tx_val && cb_q.net) wtx_d = 1'b0;
    if (pc_stb && pc_dir[1] && pc_val[1])   wtx_d = 1'b0;
    if (wr_b && cb_wdata.te && !cb_q.te)    wtx_d = 1'b1;

    wrx_d = wrx_q;
    if (fs_rx_stb && fs_rx_val && cb_q.net) wrx_d = 1'b0;
    if (pc_stb && pc_dir[0] && pc_val[0])   wrx_d = 1'b0;
    if (wr_b && cb_wdata.re && !cb_q.re)    wrx_d = 1'b1;

    play_d = play_q;
    if (pc_stb && pc_dir[1]) play_d = pc_val[1];

    htx_stb_d = 1'b0;
    htx_val_d = 1'b0;
    if (pc_stb && pc_dir[1] && !pc_val[1]) begin
      htx_stb_d = 1'b1;
    end else if (tx_wr && play_q) begin
      htx_stb_d = 1'b1;
      htx_val_d = 1'b1;
    end

    hrx_d = pc_stb && pc_dir[0] && pc_val[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_q      <= '0;
      div_q     <= '0;
      cb_q      <= '0;
      wtx_q     <= 1'b1;
      wrx_q     <= 1'b1;
      play_q    <= 1'b0;
      hrx_q     <= 1'b0;
      htx_stb_q <= 1'b0;
      htx_val_q <= 1'b0;
    end else begin
      wl_q      <= wl_d;
      div_q     <= div_d;
      cb_q      <= cb_d;
      wtx_q     <= wtx_d;
      wrx_q     <= wrx_d;
      play_q    <= play_d;
      hrx_q     <= hrx_d;
      htx_stb_q <= htx_stb_d;
      htx_val_q <= htx_val_d;
    end
  end

  assign wl_code        = wl_q;
  assign div_field      = div_q;
  assign ctlb           = cb_q;
  assign wait_tx        = wtx_q;
  assign wait_rx        = wrx_q;
  assign hs_rx_sync     = hrx_q;
  assign hs_tx_sync_stb = htx_stb_q;
  assign hs_tx_sync_val = htx_val_q;

endmodule

// File: rtl/ssi_flags.sv
module ssi_flags
  import ssi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tx_evt,
  input  logic  rx_evt,
  input  logic  tx_wr,
  input  logic  stat_wr,
  input  logic  rx_rd,
  input  logic  net_mode,
  input  logic  fs_tx_stb,
  input  logic  fs_tx_val,
  input  logic  fs_rx_stb,
  input  logic  fs_rx_val,
  output stat_t stat
);

  stat_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (tx_evt)                 st_d.tde = 1'b1;
    else if (tx_wr || stat_wr)  st_d.tde = 1'b0;
    if (rx_evt)                 st_d.rdf = 1'b1;
    else if (rx_rd)             st_d.rdf = 1'b0;
    if (fs_tx_stb) st_d.tfs = net_mode ? fs_tx_val : 1'b1;
    if (fs_rx_stb) st_d.rfs = net_mode ? fs_rx_val : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '{tde: 1'b1, default: 1'b0};
    end else begin
      st_q <= st_d;
    end
  end

  assign stat = st_q;

endmodule

// File: rtl/ssi_word_port.sv
module ssi_word_port
  import ssi_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int AW     = ADDR_W,
  parameter int DW_DIV = DIV_W,
  localparam int CAW   = 2 + DW_DIV,
  localparam int FDW   = DW_DIV + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_evt,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_irq,
  input  logic              rx_evt,
  input  logic [DATA_W-1:0] rx_in,
  output logic              rx_irq,
  input  logic              fs_tx_stb,
  input  logic              fs_tx_val,
  input  logic              fs_rx_stb,
  input  logic              fs_rx_val,
  input  logic              pc_stb,
  input  logic [1:0]        pc_dir,
  input  logic [1:0]        pc_val,
  output logic              hs_rx_sync,
  output logic              hs_tx_sync_stb,
  output logic              hs_tx_sync_val,
  output logic [FDW-1:0]    frame_div
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // bus decode
  logic wr_a, wr_b, stat_wr, tx_wr, rx_rd;
  assign wr_a    = bus_wr && (bus_addr == ADR_CTLA);
  assign wr_b    = bus_wr && (bus_addr == ADR_CTLB);
  assign stat_wr = bus_wr && (bus_addr == ADR_STAT);
  assign tx_wr   = bus_wr && (bus_addr == ADR_TXW);
  assign rx_rd   = bus_rd && (bus_addr == ADR_RXW);

  logic [1:0]        wl_code;
  logic [DW_DIV-1:0] div_field;
  ctlb_t             ctlb;
  logic              wait_tx, wait_rx;
  stat_t             stat;

  ssi_ctl_regs #(.DW_DIV(DW_DIV)) u_ctl (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .wr_a           (wr_a),
    .wr_b           (wr_b),
    .ca_wdata       (bus_wdata[CAW-1:0]),
    .cb_wdata       (ctlb_t'(bus_wdata[7:0])),
    .tx_wr          (tx_wr),
    .fs_tx_stb      (fs_tx_stb),
    .fs_tx_val      (fs_tx_val),
    .fs_rx_stb      (fs_rx_stb),
    .fs_rx_val      (fs_rx_val),
    .pc_stb         (pc_stb),
    .pc_dir         (pc_dir),
    .pc_val         (pc_val),
    .wl_code        (wl_code),
    .div_field      (div_field),
    .ctlb           (ctlb),
    .wait_tx        (wait_tx),
    .wait_rx        (wait_rx),
    .hs_rx_sync     (hs_rx_sync),
    .hs_tx_sync_stb (hs_tx_sync_stb),
    .hs_tx_sync_val (hs_tx_sync_val)
  );

  ssi_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tx_evt    (tx_evt),
    .rx_evt    (rx_evt),
    .tx_wr     (tx_wr),
    .stat_wr   (stat_wr),
    .rx_rd     (rx_rd),
    .net_mode  (ctlb.net),
    .fs_tx_stb (fs_tx_stb),
    .fs_tx_val (fs_tx_val),
    .fs_rx_stb (fs_rx_stb),
    .fs_rx_val (fs_rx_val),
    .stat      (stat)
  );

  // data words
  logic [DATA_W-1:0] txw_q, txw_d;
  logic [DATA_W-1:0] rxw_q, rxw_d;
  logic [DATA_W-1:0] txo_q, txo_d;
  logic [DATA_W-1:0] tx_shaped, rx_shaped;
  logic              tirq_q, tirq_d, rirq_q, rirq_d;
  logic              tx_pass, rx_pass;

  ssi_word_shaper #(.DATA_W(DATA_W), .TO_LINE(1'b1)) u_tx_shape (
    .wl_code (wl_code),
    .reverse (ctlb.shfd),
    .din     (txw_q),
    .dout    (tx_shaped)
  );

  ssi_word_shaper #(.DATA_W(DATA_W), .TO_LINE(1'b0)) u_rx_shape (
    .wl_code (wl_code),
    .reverse (ctlb.shfd),
    .din     (rx_in),
    .dout    (rx_shaped)
  );

  assign tx_pass = ctlb.te && !wait_tx;
  assign rx_pass = ctlb.re && !wait_rx;

  always_comb begin
    txw_d = txw_q;
    if (tx_wr) txw_d = bus_wdata;

    txo_d  = txo_q;
    tirq_d = 1'b0;
    if (tx_evt) begin
      txo_d  = tx_pass ? tx_shaped : '0;
      tirq_d = tx_pass && ctlb.tie;
    end

    rxw_d  = rxw_q;
    rirq_d = 1'b0;
    if (rx_evt) begin
      rxw_d  = rx_pass ? rx_shaped : '0;
      rirq_d = rx_pass && ctlb.rie;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      txw_q  <= '0;
      rxw_q  <= '0;
      txo_q  <= '0;
      tirq_q <= 1'b0;
      rirq_q <= 1'b0;
    end else begin
      txw_q  <= txw_d;
      rxw_q  <= rxw_d;
      txo_q  <= txo_d;
      tirq_q <= tirq_d;
      rirq_q <= rirq_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CTLA: bus_rdata[CAW-1:0] = {div_field, wl_code};
      ADR_CTLB: bus_rdata[7:0]     = ctlb;
      ADR_STAT: bus_rdata[3:0]     = stat;
      ADR_TXW:  bus_rdata          = txw_q;
      ADR_RXW:  bus_rdata          = rxw_q;
      default:  bus_rdata          = '0;
    endcase
  end

  assign tx_data   = txo_q;
  assign tx_irq    = tirq_q;
  assign rx_irq    = rirq_q;
  assign frame_div = FDW'(div_field) + FDW'(1);

endmodule

// File: rtl/ssi_word_port_chk.sv
module ssi_word_port_chk
  import ssi_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int AW     = ADDR_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic              tx_evt,
  input logic              rx_evt,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_irq,
  input logic              fs_tx_stb,
  input logic              ctl_te,
  input logic              ctl_net,
  input logic              wait_tx,
  input stat_t             stat
);

  // R4
  tx_empty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> stat.tde);

  // R5
  rx_full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> stat.rdf);

  // R4
  tx_gate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt && (!ctl_te || wait_tx)) |=> (tx_data == '0));

  // R6
  enable_arms_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_te) |-> wait_tx);

  // R7
  normal_tfs_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_tx_stb && !ctl_net) |=> stat.tfs);

  // R9
  tx_irq_follows_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(tx_evt));

  // R8
  tx_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == ADR_TXW) && !tx_evt) |=> !stat.tde);

endmodule

bind ssi_word_port ssi_word_port_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .tx_evt    (tx_evt),
  .rx_evt    (rx_evt),
  .tx_data   (tx_data),
  .tx_irq    (tx_irq),
  .fs_tx_stb (fs_tx_stb),
  .ctl_te    (ctlb.te),
  .ctl_net   (ctlb.net),
  .wait_tx   (wait_tx),
  .stat      (stat)
);

// File: tb/ssi_word_port_test.sv
module ssi_word_port_test;

  logic        clk;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [23:0] bus_wdata, bus_rdata;
  logic        tx_evt, tx_irq, rx_evt, rx_irq;
  logic [23:0] tx_data, rx_in;
  logic        fs_tx_stb, fs_tx_val, fs_rx_stb, fs_rx_val;
  logic        pc_stb;
  logic [1:0]  pc_dir, pc_val;
  logic        hs_rx_sync, hs_tx_sync_stb, hs_tx_sync_val;
  logic [5:0]  frame_div;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  ssi_word_port uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_evt(tx_evt), .tx_data(tx_data), .tx_irq(tx_irq),
    .rx_evt(rx_evt), .rx_in(rx_in), .rx_irq(rx_irq),
    .fs_tx_stb(fs_tx_stb), .fs_tx_val(fs_tx_val),
    .fs_rx_stb(fs_rx_stb), .fs_rx_val(fs_rx_val),
    .pc_stb(pc_stb), .pc_dir(pc_dir), .pc_val(pc_val),
    .hs_rx_sync(hs_rx_sync), .hs_tx_sync_stb(hs_tx_sync_stb),
    .hs_tx_sync_val(hs_tx_sync_val), .frame_div(frame_div)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {word-length code, reverse, expected tx_data, expected RX word}
  localparam logic [50:0] VEC [8] = '{
    {2'd0, 1'b0, 24'h000012, 24'hF00000},
    {2'd1, 1'b0, 24'h000123, 24'h4F0000},
    {2'd2, 1'b0, 24'h001234, 24'h34F000},
    {2'd3, 1'b0, 24'h1234F0, 24'h1234F0},
    {2'd0, 1'b1, 24'h000048, 24'h0F0000},
    {2'd1, 1'b1, 24'h000C48, 24'h0F2000},
    {2'd2, 1'b1, 24'h002C48, 24'h0F2C00},
    {2'd3, 1'b1, 24'h0F2C48, 24'h0F2C48}
  };

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %06h expected %06h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tx_pulse();
    @(negedge clk); tx_evt = 1'b1;
    @(negedge clk); tx_evt = 1'b0;
  endtask

  task automatic rx_pulse();
    @(negedge clk); rx_evt = 1'b1;
    @(negedge clk); rx_evt = 1'b0;
  endtask

  task automatic fs_tx(input logic v);
    @(negedge clk); fs_tx_stb = 1'b1; fs_tx_val = v;
    @(negedge clk); fs_tx_stb = 1'b0;
  endtask

  task automatic fs_rx(input logic v);
    @(negedge clk); fs_rx_stb = 1'b1; fs_rx_val = v;
    @(negedge clk); fs_rx_stb = 1'b0;
  endtask

  task automatic pc(input logic [1:0] dir, input logic [1:0] val);
    @(negedge clk); pc_stb = 1'b1; pc_dir = dir; pc_val = val;
    @(negedge clk); pc_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] r;
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    tx_evt = 0; rx_evt = 0; rx_in = 24'h1234F0;
    fs_tx_stb = 0; fs_tx_val = 0; fs_rx_stb = 0; fs_rx_val = 0;
    pc_stb = 0; pc_dir = 0; pc_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    rd(3'd2, r); check("R10 status", r, 24'h000001);
    rd(3'd0, r); check("R10 ctla", r, 24'h0);
    rd(3'd1, r); check("R10 ctlb", r, 24'h0);
    check("R10 tx_data", tx_data, 24'h0);
    check("R11 div reset", {18'h0, frame_div}, 24'd1);

    // R4 disabled transmit gives zero, sets empty
    wr(3'd3, 24'h123456);
    rd(3'd2, r); check("R8 tx write clears empty", r & 24'h1, 24'h0);
    tx_pulse();
    check("R4 disabled tx", tx_data, 24'h0);
    rd(3'd2, r); check("R4 empty set", r & 24'h1, 24'h1);

    // R6 enable arms wait (network mode)
    wr(3'd1, 24'h11);
    wr(3'd3, 24'h123456);
    tx_pulse();
    check("R6 wait after enable", tx_data, 24'h0);
    fs_tx(1'b0);
    rd(3'd2, r); check("R7 net tfs low", r & 24'h4, 24'h0);
    tx_pulse();
    check("R6 sync 0 keeps wait", tx_data, 24'h0);
    fs_tx(1'b1);
    rd(3'd2, r); check("R7 net tfs high", r & 24'h4, 24'h4);
    tx_pulse();
    check("R1 8-bit default", tx_data, 24'h000012);

    // table: R1 R2 R3
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, {22'h0, VEC[i][50:49]});
      wr(3'd1, 24'h13 | (24'(VEC[i][48]) << 5));
      fs_tx(1'b1);
      fs_rx(1'b1);
      wr(3'd3, 24'h1234F0);
      tx_pulse();
      check(VEC[i][48] ? "R3 tx reversed" : "R1 tx aligned", tx_data, VEC[i][47:24]);
      rx_pulse();
      rd(3'd4, r);
      check(VEC[i][48] ? "R3 rx reversed" : "R2 rx aligned", r, VEC[i][23:0]);
    end

    // R8 clears
    rd(3'd2, r); check("R8 rx read clears full", r & 24'h2, 24'h0);
    tx_pulse();
    wr(3'd2, 24'h0);
    rd(3'd2, r); check("R8 status write clears empty", r & 24'h1, 24'h0);
    rx_pulse();
    rd(3'd2, r); check("R5 full set", r & 24'h2, 24'h2);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 24'h0; tx_evt = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tx_evt = 1'b0;
    rd(3'd2, r); check("R8 event wins over clear", r & 24'h1, 24'h1);

    // R9 interrupts
    wr(3'd1, 24'h1F);
    tx_pulse();
    check("R9 tx irq pulse", {23'h0, tx_irq}, 24'h1);
    @(negedge clk);
    check("R9 tx irq single", {23'h0, tx_irq}, 24'h0);
    rx_pulse();
    check("R9 rx irq pulse", {23'h0, rx_irq}, 24'h1);

    // R5 receive disabled loads zero
    wr(3'd1, 24'h11);
    rx_pulse();
    rd(3'd4, r); check("R5 disabled rx zero", r, 24'h0);

    // R7 normal mode flags forced
    wr(3'd1, 24'h00);
    fs_tx(1'b0);
    fs_rx(1'b0);
    rd(3'd2, r); check("R7 normal flags", r & 24'hC, 24'hC);

    // R6 normal mode: sync does not clear wait
    wr(3'd3, 24'hABCDEF);
    wr(3'd1, 24'h01);
    fs_tx(1'b1);
    tx_pulse();
    check("R6 normal keeps wait", tx_data, 24'h0);

    // R12 handshake, transmit side
    wr(3'd0, 24'h3);
    pc(2'b10, 2'b10);
    tx_pulse();
    check("R12 play clears wait", tx_data, 24'hABCDEF);
    wr(3'd3, 24'h111111);
    check("R12 armed sync stb", {22'h0, hs_tx_sync_stb, hs_tx_sync_val}, 24'h3);
    pc(2'b10, 2'b00);
    check("R12 disarm sync", {22'h0, hs_tx_sync_stb, hs_tx_sync_val}, 24'h2);
    wr(3'd3, 24'h222222);
    check("R12 disarmed no sync", {23'h0, hs_tx_sync_stb}, 24'h0);

    // R12 handshake, receive side
    wr(3'd1, 24'h02);
    rx_pulse();
    rd(3'd4, r); check("R12 rx waiting", r, 24'h0);
    pc(2'b01, 2'b01);
    check("R12 rx sync pulse", {23'h0, hs_rx_sync}, 24'h1);
    rx_pulse();
    rd(3'd4, r); check("R12 rx after handshake", r, 24'h1234F0);

    // R11 R13 divider and readback
    wr(3'd0, 24'h7F);
    check("R11 div max", {18'h0, frame_div}, 24'd32);
    rd(3'd0, r); check("R13 ctla readback", r, 24'h00007F);
    wr(3'd1, 24'hFFFFC0);
    rd(3'd1, r); check("R13 ctlb readback", r, 24'h0000C0);

    finish_run();
  end

endmodule